// File: doc/BRIEF.md
# Register Access Permission Gate

This block sits between a serial command decoder and a register file. Each decoded command is a read or a write with a register address and write data. The block decides whether the register file may carry it out. A constant parameter table holds one readable bit and one writable bit for each address. A lock flag, taken from an initialization-complete bit in a configuration register, freezes every write except writes to one device-control register.

One cycle after a command is presented, the block gives exactly one of three results:

- a read grant strobe,
- a write grant strobe, carrying the address and data,
- a reject strobe.

A two-bit response code goes with the result. It lets the response framer send a dedicated invalid-request answer in place of data. A rejected command never reaches the register file. Rejected writes therefore change nothing, and rejected reads cannot fire side effects such as clear-on-read.

Top module: `regperm_gate`

## Requirements
- R1: A read of an address whose readable bit is 1 gives `grant_rd` high for one cycle, in the cycle after the command. `grant_addr` equals the command address, and `resp_code` is 2'b01. The lock flag does not affect reads.
- R2: A read of an address whose readable bit is 0, or of any address at or above NREG, gives `reject` high and `resp_code` 2'b11. `grant_rd` stays low, so no read side effect can happen.
- R3: A write to an address whose writable bit is 1, while the lock is low, gives `grant_wr` high for one cycle in the next cycle. `grant_addr` and `grant_wdata` equal the command address and data, and `resp_code` is 2'b10.
- R4: A write to an address whose writable bit is 0, or to any address at or above NREG, gives `reject` with `resp_code` 2'b11. `grant_wr` stays low, so no register changes.
- R5: While the lock flag is high, a write to any address other than CTRL_ADDR is rejected (`reject`, `resp_code` 2'b11, no `grant_wr`), even if the address is writable.
- R6: A write to CTRL_ADDR is granted whether the lock is high or low, provided its writable bit is 1.
- R7: The lock flag is sampled only in the cycle the command is presented. A write presented while the lock is low is granted even if the lock rises in the next cycle. This lets the write that sets the lock complete.
- R8: For each command exactly one of `grant_rd`, `grant_wr` and `reject` pulses, for one cycle. In a cycle with no command in the cycle before, all three are low and `resp_code` is 2'b00.
- R9: During and straight after reset, `grant_rd`, `grant_wr` and `reject` are low and `resp_code` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_write | input | 1 | 1 for a write, 0 for a read |
| cmd_addr | input | AW | Register address of the command |
| cmd_wdata | input | DW | Write data of the command |
| lock_in | input | 1 | Initialization-complete bit from the configuration register |
| grant_rd | output | 1 | One-cycle strobe: the read may go ahead |
| grant_wr | output | 1 | One-cycle strobe: the write may go ahead |
| grant_addr | output | AW | Address forwarded with a grant |
| grant_wdata | output | DW | Write data forwarded with a write grant |
| reject | output | 1 | One-cycle strobe: invalid register request |
| resp_code | output | 2 | 00 idle, 01 read granted, 10 write granted, 11 invalid request |

## Verification
The only state in the block is the one-cycle result register. A wrong internal decision shows at the ports in the very next cycle. It appears as a grant where a reject was due, or the reverse, or as a response code that does not match the strobe. A table bit, a lock decode or an exemption compare that is wrong shows up the first time a command hits the affected address. So the stimulus covers every address in both directions, under both lock levels. A strobe that lingers shows in the following idle cycle, where all outputs must read zero.

// File: rtl/regperm_gate.sv
module regperm_gate #(
  parameter int AW = 5,
  parameter int DW = 8,
  parameter int NREG = 24,
  parameter logic [NREG-1:0] RD_MASK = 24'hEF_FFF7,
  parameter logic [NREG-1:0] WR_MASK = 24'h00_3F0E,
  parameter int CTRL_ADDR = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic          lock_in,
  output logic          grant_rd,
  output logic          grant_wr,
  output logic [AW-1:0] grant_addr,
  output logic [DW-1:0] grant_wdata,
  output logic          reject,
  output logic [1:0]    resp_code
);
  localparam int SPAN = 1 << AW;
  localparam logic [1:0] RC_IDLE = 2'b00;
  localparam logic [1:0] RC_RD   = 2'b01;
  localparam logic [1:0] RC_WR   = 2'b10;
  localparam logic [1:0] RC_BAD  = 2'b11;

  logic [SPAN-1:0] rd_tab, wr_tab;

  for (genvar i = 0; i < SPAN; i++) begin : g_tab
    if (i < NREG) begin : g_in
      assign rd_tab[i] = RD_MASK[i];
      assign wr_tab[i] = WR_MASK[i];
    end else begin : g_out
      assign rd_tab[i] = 1'b0;
      assign wr_tab[i] = 1'b0;
    end
  end

  logic is_ctrl, rd_ok, wr_ok, go_rd, go_wr, go_bad;

  assign is_ctrl = (cmd_addr == AW'(CTRL_ADDR));
  assign rd_ok   = rd_tab[cmd_addr];
  assign wr_ok   = wr_tab[cmd_addr] && (!lock_in || is_ctrl);
  assign go_rd   = cmd_valid && !cmd_write && rd_ok;
  assign go_wr   = cmd_valid &&  cmd_write && wr_ok;
  assign go_bad  = cmd_valid && !go_rd && !go_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_rd    <= 1'b0;
      grant_wr    <= 1'b0;
      reject      <= 1'b0;
      resp_code   <= RC_IDLE;
      grant_addr  <= '0;
      grant_wdata <= '0;
    end else begin
      grant_rd  <= go_rd;
      grant_wr  <= go_wr;
      reject    <= go_bad;
      resp_code <= go_rd ? RC_RD : go_wr ? RC_WR : go_bad ? RC_BAD : RC_IDLE;
      if (go_rd || go_wr) grant_addr <= cmd_addr;
      if (go_wr) grant_wdata <= cmd_wdata;
    end
  end
endmodule

// File: rtl/regperm_gate_chk.sv
module regperm_gate_chk #(
  parameter int AW = 5,
  parameter int NREG = 24,
  parameter logic [NREG-1:0] WR_MASK = 24'h00_3F0E,
  parameter int CTRL_ADDR = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_write,
  input logic [AW-1:0] cmd_addr,
  input logic          lock_in,
  input logic          grant_rd,
  input logic          grant_wr,
  input logic          reject,
  input logic [1:0]    resp_code
);
  localparam bit CTRL_WR = WR_MASK[CTRL_ADDR];

  p_one_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant_rd, grant_wr, reject}));

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !(grant_rd || grant_wr || reject) && resp_code == 2'b00);

  p_reject_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> resp_code == 2'b11);

  p_read_no_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_write |=> !grant_wr);

  p_oob_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_write && int'(cmd_addr) >= NREG |=> reject);

  p_oob_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_write && int'(cmd_addr) >= NREG |=> reject && !grant_wr);

  p_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_write && lock_in && cmd_addr != AW'(CTRL_ADDR) |=> !grant_wr);

  p_ctrl_exempt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_write && CTRL_WR && cmd_addr == AW'(CTRL_ADDR) |=> grant_wr);

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reject && !$past(cmd_valid) |-> 1'b0);
endmodule

bind regperm_gate regperm_gate_chk #(
  .AW(AW), .NREG(NREG), .WR_MASK(WR_MASK), .CTRL_ADDR(CTRL_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
  .cmd_addr(cmd_addr), .lock_in(lock_in), .grant_rd(grant_rd),
  .grant_wr(grant_wr), .reject(reject), .resp_code(resp_code)
);

// File: tb/regperm_gate_tb_top.sv
`timescale 1ns/1ps
module regperm_gate_tb_top;
  localparam int AW = 5;
  localparam int DW = 8;
  localparam int NREG = 24;
  localparam logic [NREG-1:0] RDM = 24'hEF_FFF7;
  localparam logic [NREG-1:0] WRM = 24'h00_3F0E;
  localparam int CTRL = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0, lock_in = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic grant_rd, grant_wr, reject;
  logic [AW-1:0] grant_addr;
  logic [DW-1:0] grant_wdata;
  logic [1:0] resp_code;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  regperm_gate #(.AW(AW), .DW(DW), .NREG(NREG), .RD_MASK(RDM), .WR_MASK(WRM),
                 .CTRL_ADDR(CTRL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .lock_in(lock_in),
    .grant_rd(grant_rd), .grant_wr(grant_wr), .grant_addr(grant_addr),
    .grant_wdata(grant_wdata), .reject(reject), .resp_code(resp_code));

  function automatic bit tab_rd(int a);
    return a < NREG && RDM[a];
  endfunction
  function automatic bit tab_wr(int a);
    return a < NREG && WRM[a];
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(bit v, bit w, int a, int d, bit l, string tag);
    bit er, ew, eb;
    int code;
    cmd_valid = v; cmd_write = w; cmd_addr = AW'(a); cmd_wdata = DW'(d); lock_in = l;
    er = v && !w && tab_rd(a);
    ew = v && w && tab_wr(a) && (!l || a == CTRL);
    eb = v && !er && !ew;
    code = er ? 1 : ew ? 2 : eb ? 3 : 0;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(tag, {grant_rd, grant_wr, reject, resp_code}, {er, ew, eb, code[1:0]});
    if (er || ew) check({tag, " addr"}, grant_addr, a);
    if (ew) check({tag, " wdata"}, grant_wdata, d & 8'hFF);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset", {grant_rd, grant_wr, reject, resp_code}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after reset", {grant_rd, grant_wr, reject, resp_code}, 0);
    for (int a = 0; a < 32; a++) step(1, 0, a, 0, 0, tab_rd(a) ? "R1 read" : "R2 bad read");
    for (int a = 0; a < 32; a++) step(1, 1, a, a * 7 + 3, 0, tab_wr(a) ? "R3 write" : "R4 bad write");
    for (int a = 0; a < 32; a++) step(1, 1, a, a ^ 8'h5A, 1, a == CTRL ? "R6 ctrl locked" : "R5 locked write");
    for (int a = 0; a < 32; a++) step(1, 0, a, 0, 1, "R1 read locked");
    step(0, 1, 8, 1, 0, "R8 idle");
    step(1, 1, 9, 8'hC3, 0, "R7 write before lock");
    step(1, 1, 9, 8'h3C, 1, "R7 write after lock");
    step(1, 1, CTRL, 8'hA5, 1, "R6 ctrl");
    step(0, 0, 0, 0, 1, "R8 no linger");
    step(1, 0, 3, 0, 0, "R2 write-only read");
    step(1, 0, 20, 0, 1, "R2 hole read");
    step(1, 1, 0, 8'hFF, 0, "R4 read-only write");
    step(0, 0, 0, 0, 0, "R8 idle end");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule